// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Byte Error Tags

This block is the receive half of a classic asynchronous serial port. A divisor counter turns the core clock into a sampling tick at sixteen times the bit rate. The input line is synchronised, and each start bit is validated at its midpoint. Eight data bits are then captured least significant bit first, followed by an optional parity bit and one stop bit. Every completed character goes into a small receive queue together with three tags: parity error, framing error and break. The tags stay attached to their own byte. The status outputs show them only while that byte is at the head of the queue.

On the CPU side there are two strobes. One pops the head byte. The other acts as a status read: it clears the sticky overrun flag, hides the head byte's tags until the next pop, and lets the queue-error summary fall once no tagged byte is left. Queue mode can be switched off. The receiver then keeps a single holding byte and the summary bit reads 0. A line-status interrupt request is raised from the visible error bits when it is enabled.

Top module: `uart_rx_tagged`

## Requirements
- R1: A sampling tick occurs once every `divisor` clocks, and one bit lasts 16 ticks. A character is a low start bit, then 8 data bits least significant bit first, then an optional parity bit, then a stop bit. When the stop sample is high, the byte is stored with all three tags clear.
- R2: A low level on the idle line starts reception only if the line is still low at the 8th tick. A shorter low pulse stores nothing and returns the receiver to idle.
- R3: When `parity_en` is 1, the expected parity bit is the XOR of the 8 data bits. It is inverted when `parity_odd` is 1. A mismatch stores the byte with its parity tag set.
- R4: A low stop sample that is not a break stores the byte with its framing tag set. That low level is then accepted as a validated start bit, and the next 8 bit periods are shifted in as data.
- R5: When every sample from the start bit through the stop bit is low, one entry of data 0x00 is stored with only the break tag set. No further entry is stored for the rest of the low period, however long it lasts.
- R6: After a break, reception restarts only once the line has been high for 8 consecutive ticks (half a bit). A low sample before that restarts the count.
- R7: `dout` shows the head byte and `data_ready` is 1 while the queue holds a byte. `pe`, `fe` and `bi` show the tags of the head byte only. A `rd_data` pulse removes the head byte.
- R8: A `rd_status` pulse hides the head byte's `pe`, `fe` and `bi` until the next pop, and it clears `oe`.
- R9: The queue holds `DEPTH` bytes when `fifo_mode` is 1 and one byte when it is 0. A byte that completes while the queue is full is dropped, `oe` is set, and the head byte is unchanged.
- R10: `fifo_err` is 0 when `fifo_mode` is 0. When `fifo_mode` is 1, `fifo_err` becomes 1 while any stored byte carries a tag, and a status read clears it only when no tagged byte remains.
- R11: `ls_irq` is 1 exactly when `ls_int_en` is 1 and at least one of `oe`, `pe`, `fe` or `bi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clocks per sampling tick |
| rxd | input | 1 | Serial receive line, idle high |
| fifo_mode | input | 1 | 1: queue of DEPTH bytes, 0: single holding byte |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| ls_int_en | input | 1 | Enables the line-status interrupt request |
| rd_data | input | 1 | One-cycle pulse that pops the head byte |
| rd_status | input | 1 | One-cycle pulse that acts as a status read |
| dout | output | 8 | Head byte |
| data_ready | output | 1 | Queue holds at least one byte |
| pe | output | 1 | Parity tag of the head byte |
| fe | output | 1 | Framing tag of the head byte |
| bi | output | 1 | Break tag of the head byte |
| oe | output | 1 | Sticky overrun flag |
| fifo_err | output | 1 | A tagged byte is stored (queue mode only) |
| ls_irq | output | 1 | Line-status interrupt request |

## Verification
The bench uses the default `DEPTH` of 16 and `OSR` of 16 with two synchroniser stages. It drives `divisor` at 4, so a bit lasts 64 clocks. With a bit that short, a full queue plus one extra byte fits into a short run, and the overrun path (including the 17th dropped byte) is checked in both queue sizes. The long break, the half-bit recovery window interrupted by an early low, and the framing resynchronisation that creates a second byte all complete within a few thousand clocks each.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   // One stored character: three error tags above the data byte.
   typedef struct packed {
      logic       brk;
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_entry_t;

   function automatic logic is_tagged(input rx_entry_t e);
      return e.brk | e.ferr | e.perr;
   endfunction
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;

   // A divisor of zero behaves like a divisor of one.
   assign limit = (divisor == '0) ? '0 : divisor - 1'b1;
   assign tick  = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx,
   input  logic      parity_en,
   input  logic      parity_odd,
   output logic      push,
   output rx_entry_t push_entry
);
   localparam int CW = $clog2(OSR);
   localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} state_t;

   state_t        st;
   logic [CW-1:0] tcnt;
   logic [2:0]    bitn;
   logic [7:0]    shreg;
   logic          par_bad;
   logic          all_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         tcnt       <= '0;
         bitn       <= '0;
         shreg      <= '0;
         par_bad    <= 1'b0;
         all_low    <= 1'b0;
         push       <= 1'b0;
         push_entry <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            unique case (st)
               S_IDLE: begin
                  if (!rx) begin
                     st   <= S_START;
                     tcnt <= '0;
                  end
               end
               S_START: begin
                  if (tcnt == MID) begin
                     tcnt    <= '0;
                     bitn    <= '0;
                     par_bad <= 1'b0;
                     all_low <= 1'b1;
                     st      <= rx ? S_IDLE : S_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               S_DATA: begin
                  if (tcnt == LAST) begin
                     tcnt    <= '0;
                     shreg   <= {rx, shreg[7:1]};
                     all_low <= all_low & ~rx;
                     bitn    <= bitn + 1'b1;
                     if (bitn == 3'd7) st <= parity_en ? S_PAR : S_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               S_PAR: begin
                  if (tcnt == LAST) begin
                     tcnt    <= '0;
                     par_bad <= rx ^ (^shreg) ^ parity_odd;
                     all_low <= all_low & ~rx;
                     st      <= S_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               S_STOP: begin
                  if (tcnt == LAST) begin
                     tcnt <= '0;
                     push <= 1'b1;
                     if (rx) begin
                        push_entry <= '{brk: 1'b0, ferr: 1'b0, perr: par_bad, data: shreg};
                        st         <= S_IDLE;
                     end else if (all_low) begin
                        push_entry <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: 8'h00};
                        st         <= S_BRK;
                     end else begin
                        // Bad stop level is taken as an already validated start bit.
                        push_entry <= '{brk: 1'b0, ferr: 1'b1, perr: par_bad, data: shreg};
                        bitn       <= '0;
                        par_bad    <= 1'b0;
                        all_low    <= 1'b1;
                        st         <= S_DATA;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               S_BRK: begin
                  if (!rx)              tcnt <= '0;
                  else if (tcnt == MID) begin
                     tcnt <= '0;
                     st   <= S_IDLE;
                  end else              tcnt <= tcnt + 1'b1;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fifo_mode,
   input  logic      push,
   input  rx_entry_t wentry,
   input  logic      pop,
   output rx_entry_t head,
   output logic      empty,
   output logic      drop
);
   localparam int AW = $clog2(DEPTH);

   rx_entry_t     mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          full, do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = fifo_mode ? (cnt == (AW+1)'(DEPTH)) : !empty;
   assign drop    = push & full;
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wentry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
   import uart_rx_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int DEPTH       = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             rxd,
   input  logic             fifo_mode,
   input  logic             parity_en,
   input  logic             parity_odd,
   input  logic             ls_int_en,
   input  logic             rd_data,
   input  logic             rd_status,
   output logic [7:0]       dout,
   output logic             data_ready,
   output logic             pe,
   output logic             fe,
   output logic             bi,
   output logic             oe,
   output logic             fifo_err,
   output logic             ls_irq
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic      rx_s, tick, eng_push, drop, empty, popping, accepted;
   rx_entry_t eng_entry, head;
   logic [AW:0] flag_cnt;
   logic      flagged_stored, err_r, oe_r, mask_r;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= (sh << 1) | SYNC_STAGES'(rxd);
         end
         assign rx_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
   );

   uart_rx_engine #(.OSR(OSR)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
      .parity_en(parity_en), .parity_odd(parity_odd),
      .push(eng_push), .push_entry(eng_entry)
   );

   uart_rx_queue #(.DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
      .push(eng_push), .wentry(eng_entry), .pop(rd_data),
      .head(head), .empty(empty), .drop(drop)
   );

   assign popping        = rd_data & ~empty;
   assign accepted       = eng_push & ~drop;
   assign flagged_stored = (flag_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_cnt <= '0;
         err_r    <= 1'b0;
         oe_r     <= 1'b0;
         mask_r   <= 1'b0;
      end else begin
         case ({accepted & is_tagged(eng_entry), popping & is_tagged(head)})
            2'b10:   flag_cnt <= flag_cnt + 1'b1;
            2'b01:   flag_cnt <= flag_cnt - 1'b1;
            default: flag_cnt <= flag_cnt;
         endcase
         if (flagged_stored) err_r <= 1'b1;
         else if (rd_status) err_r <= 1'b0;
         if (drop)           oe_r <= 1'b1;
         else if (rd_status) oe_r <= 1'b0;
         if (popping || empty) mask_r <= 1'b0;
         else if (rd_status)   mask_r <= 1'b1;
      end
   end

   assign dout       = head.data;
   assign data_ready = ~empty;
   assign pe         = ~empty & head.perr & ~mask_r;
   assign fe         = ~empty & head.ferr & ~mask_r;
   assign bi         = ~empty & head.brk  & ~mask_r;
   assign oe         = oe_r;
   assign fifo_err   = fifo_mode & err_r;
   assign ls_irq     = ls_int_en & (oe_r | pe | fe | bi);
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_mode,
   input logic       rd_data,
   input logic       rd_status,
   input logic [7:0] dout,
   input logic       data_ready,
   input logic       oe,
   input logic       fifo_err,
   input logic       eng_push,
   input logic       accepted,
   input logic       flagged_stored
);
   // R9: a completed byte that finds no room raises overrun next cycle
   a_r9_drop_sets_oe: assert property (@(posedge clk) disable iff (!rst_n)
      eng_push && !accepted |=> oe);

   // R9: without a pop the head byte stays put, whatever arrives behind it
   a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready && !rd_data |=> data_ready && $stable(dout));

   // R7: the queue only empties through a pop
   a_r7_pop_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> $past(rd_data));

   // R10: tagged bytes in storage drive the summary bit in queue mode
   a_r10_err_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_mode && flagged_stored |=> fifo_err || !fifo_mode);

   // R10: the summary bit falls only after a status read or a mode change
   a_r10_err_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fifo_err) |-> $past(rd_status) || !fifo_mode);

   // R5: stored characters are at least a bit apart, so a break is a single push
   a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
      eng_push |=> !eng_push);
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rd_data(rd_data),
   .rd_status(rd_status), .dout(dout), .data_ready(data_ready), .oe(oe),
   .fifo_err(fifo_err), .eng_push(eng_push), .accepted(accepted),
   .flagged_stored(flagged_stored)
);

// File: tb/uart_rx_tagged_bench.sv
`timescale 1ns/1ps
module uart_rx_tagged_bench;
   localparam int DIV   = 4;
   localparam int BIT   = 16 * DIV;
   localparam int DEPTH = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] divisor = 16'(DIV);
   logic rxd = 1'b1, fifo_mode = 1'b1, parity_en = 1'b0, parity_odd = 1'b0;
   logic ls_int_en = 1'b1, rd_data = 1'b0, rd_status = 1'b0;
   logic [7:0] dout;
   logic data_ready, pe, fe, bi, oe, fifo_err, ls_irq;

   int n_tests = 0, n_fail = 0;
   bit settled = 1'b0, done = 1'b0;
   logic [7:0] mq[$];

   always #4 clk = ~clk;

   uart_rx_tagged u_uart_rx_tagged (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .rxd(rxd),
      .fifo_mode(fifo_mode), .parity_en(parity_en), .parity_odd(parity_odd),
      .ls_int_en(ls_int_en), .rd_data(rd_data), .rd_status(rd_status),
      .dout(dout), .data_ready(data_ready), .pe(pe), .fe(fe), .bi(bi),
      .oe(oe), .fifo_err(fifo_err), .ls_irq(ls_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Reference queue compared with the outputs on every quiet clock (R7, R9).
   always @(negedge clk) begin
      if (settled && !done) begin
         n_tests++;
         if (data_ready !== (mq.size() != 0) ||
             (mq.size() != 0 && dout !== mq[0])) begin
            n_fail++;
            $display("FAIL R7 model: actual ready %0b dout %0h expected ready %0b dout %0h",
                     data_ready, dout, mq.size() != 0, (mq.size() != 0) ? mq[0] : 8'h00);
         end
      end
   end

   task automatic line(input logic v, input int clocks);
      @(negedge clk) rxd = v;
      repeat (clocks - 1) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input bit use_par, input bit par_bit,
                       input bit stop_bit, input int idle_bits);
      settled = 1'b0;
      line(1'b0, BIT);
      for (int i = 0; i < 8; i++) line(d[i], BIT);
      if (use_par) line(par_bit, BIT);
      line(stop_bit, BIT);
      line(1'b1, idle_bits * BIT);
   endtask

   task automatic expect_byte(input logic [7:0] d);
      int cap;
      cap = fifo_mode ? DEPTH : 1;
      if (mq.size() < cap) mq.push_back(d);
   endtask

   task automatic pop();
      @(negedge clk) rd_data = 1'b1;
      @(posedge clk) #1 rd_data = 1'b0;
      if (mq.size() != 0) void'(mq.pop_front());
      @(negedge clk);
   endtask

   task automatic status_read();
      @(negedge clk) rd_status = 1'b1;
      @(posedge clk) #1 rd_status = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R7 reset ready", data_ready, 0);
      chk("R10 reset fifo_err", fifo_err, 0);
      chk("R11 reset irq", ls_irq, 0);
      chk("R8 reset oe", oe, 0);
      line(1'b1, 2 * BIT);
      settled = 1'b1;

      // R1: plain byte, no parity
      send(8'hA5, 0, 0, 1, 2); expect_byte(8'hA5); settled = 1'b1;
      chk("R1 data", dout, 8'hA5);
      chk("R1 tags", {pe, fe, bi}, 0);
      pop();
      chk("R7 emptied", data_ready, 0);

      // R2: short low pulse
      settled = 1'b0;
      line(1'b0, 16);
      line(1'b1, 12 * BIT);
      settled = 1'b1;
      chk("R2 glitch ignored", data_ready, 0);

      // R3 / R7 / R10: even parity, tags per byte
      parity_en = 1'b1;
      send(8'h3C, 1, 0, 1, 1); expect_byte(8'h3C);
      send(8'h07, 1, 0, 1, 1); expect_byte(8'h07);
      send(8'h81, 1, 0, 1, 1); expect_byte(8'h81);
      settled = 1'b1;
      chk("R7 head clean", pe, 0);
      chk("R11 no irq clean head", ls_irq, 0);
      chk("R10 fifo_err set", fifo_err, 1);
      pop();
      chk("R3 parity tag", pe, 1);
      chk("R11 irq on pe", ls_irq, 1);
      status_read();
      chk("R8 pe hidden", pe, 0);
      chk("R10 err kept while tagged", fifo_err, 1);
      pop();
      chk("R3 good parity", pe, 0);
      status_read();
      chk("R10 err cleared", fifo_err, 0);
      pop();

      // R3: odd parity
      parity_odd = 1'b1;
      send(8'h07, 1, 0, 1, 1); expect_byte(8'h07); settled = 1'b1;
      chk("R3 odd parity ok", pe, 0);
      pop();
      send(8'h07, 1, 1, 1, 1); expect_byte(8'h07); settled = 1'b1;
      chk("R3 odd parity bad", pe, 1);
      pop();
      status_read();
      parity_odd = 1'b0;
      parity_en  = 1'b0;

      // R4: framing error and resync
      send(8'h55, 0, 0, 0, 11); expect_byte(8'h55); expect_byte(8'hFF); settled = 1'b1;
      chk("R4 framing tag", fe, 1);
      pop();
      chk("R4 resync byte", dout, 8'hFF);
      chk("R4 resync clean", fe, 0);
      pop();
      status_read();

      // R5 / R6: break, brief high, low again, then recovery
      settled = 1'b0;
      line(1'b0, 30 * BIT);
      line(1'b1, 16);
      line(1'b0, 20 * BIT);
      line(1'b1, 2 * BIT);
      expect_byte(8'h00); settled = 1'b1;
      chk("R5 break tag", bi, 1);
      chk("R5 break no fe", fe, 0);
      chk("R11 irq on bi", ls_irq, 1);
      status_read();
      chk("R8 bi hidden", bi, 0);
      chk("R8 byte kept", data_ready, 1);
      pop();
      chk("R5 R6 single break byte", data_ready, 0);
      send(8'h5A, 0, 0, 1, 1); expect_byte(8'h5A); settled = 1'b1;
      chk("R6 restart after break", dout, 8'h5A);
      pop();
      status_read();

      // R9 / R10 / R11: single holding byte
      fifo_mode = 1'b0;
      parity_en = 1'b1;
      send(8'h07, 1, 0, 1, 1); expect_byte(8'h07);
      settled = 1'b1;
      chk("R10 legacy zero", fifo_err, 0);
      send(8'h22, 1, 0, 1, 1); expect_byte(8'h22); settled = 1'b1;
      chk("R9 overrun set", oe, 1);
      chk("R9 head kept", dout, 8'h07);
      chk("R11 irq", ls_irq, 1);
      status_read();
      chk("R8 oe cleared", oe, 0);
      chk("R11 irq cleared", ls_irq, 0);
      pop();
      parity_en = 1'b0;

      // R9: full queue
      fifo_mode = 1'b1;
      for (int i = 0; i <= DEPTH; i++) begin
         send(8'(i + 8'h40), 0, 0, 1, 1);
         expect_byte(8'(i + 8'h40));
      end
      settled = 1'b1;
      chk("R9 queue overrun", oe, 1);
      chk("R9 head is first", dout, 8'h40);
      status_read();
      chk("R8 oe cleared fifo", oe, 0);
      for (int i = 0; i < DEPTH; i++) pop();
      chk("R9 drained", data_ready, 0);

      settled = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule